// File: doc/BRIEF.md
# Board Control Register Block

A small control and status peripheral that sits on a simple synchronous bus. The bus carries an address, a write strobe with write data, and a read strobe. Read data is returned from a register. Through this bus, software can read a fixed build code and the processor clock rate. It can also read and set a bank of LED outputs, read the state of a group of DIP switch inputs, and ask for a board reset. The block decodes a 64 KiB window, and every register in it is 32 bits wide.

The board reset is guarded by a key. Only a write of the exact word 0x0000DEAD to the reset slot raises the reset request output, and it does so for one clock. Any other value written there has no effect. The switch inputs are asynchronous to the bus clock, so they pass through a two-stage synchronizer before the readable copy is loaded.

Top module: `board_ctrl_regs`

## Requirements
- R1: While `rst` is high, and after it is released, `led_out`, `reset_req` and `bus_rdata` are zero, and a read of the LED slot returns zero.
- R2: A read of word index 0 (byte offset 0x0) returns the build code 0x09272011.
- R3: A read of word index 1 (byte offset 0x4) returns the value of parameter `CLK_HZ` (default 10,000,000).
- R4: A write to word index 2 (offset 0x8) stores `bus_wdata[LED_W-1:0]`. The value appears on `led_out` after that clock edge. A read of this index returns the stored value zero-extended to 32 bits, where 1 means lit.
- R5: A read of word index 3 (offset 0xC) returns `sw_in` zero-extended. A change on `sw_in` first becomes visible to a read sampled on the fourth rising edge after the change. A read sampled on the third edge still returns the old value.
- R6: A write of exactly 0x0000DEAD to word index 4 (offset 0x10) raises `reset_req` on the edge that accepts the write. Any other value written there leaves `reset_req` low. A read of index 4 returns zero.
- R7: `reset_req` is never high on two consecutive cycles. A key write accepted in the cycle straight after a pulse is absorbed.
- R8: Reads of word indices 5 and above return zero. Writes to any index other than 2 and 4 change neither `led_out` nor any readable value.
- R9: Only `bus_addr[15:2]` selects a register. Address bits 1:0 and bits above 15 have no effect on decoding.
- R10: Read data is registered. `bus_rdata` holds the selected value in the cycle after `bus_rd` is sampled high, and it is zero in the cycle after `bus_rd` is sampled low. A read and a write of the LED slot in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address, low 16 bits decoded |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| sw_in | input | SW_W | Asynchronous DIP switch levels |
| led_out | output | LED_W | LED drive, 1 means lit |
| reset_req | output | 1 | One-cycle board reset request |

## Verification
The assertions assume that `bus_wr`, `bus_rd`, `bus_addr` and `bus_wdata` carry known values at every rising edge once reset is released. They also assume that the reset-slot key check looks at the full 32-bit data word. The stimulus changes every bus input only on the falling clock edge and never leaves a strobe unknown. It holds `sw_in` steady through each random phase and lets it settle for several cycles before the next switch read. The random writes are separated by an idle cycle, so back-to-back key writes appear only in the directed case that targets them.

// File: rtl/board_ctrl_pkg.sv
package board_ctrl_pkg;

    localparam int DATA_W = 32;
    localparam int OFS_W  = 16;
    localparam int IDX_W  = OFS_W - 2;

    localparam logic [DATA_W-1:0] BUILD_CODE = 32'h0927_2011;
    localparam logic [DATA_W-1:0] RESET_KEY  = 32'h0000_DEAD;

    typedef enum logic [2:0] {
        SEL_ID    = 3'd0,
        SEL_FREQ  = 3'd1,
        SEL_LED   = 3'd2,
        SEL_SW    = 3'd3,
        SEL_RESET = 3'd4,
        SEL_NONE  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        reg_sel_e          sel;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic reg_sel_e idx_to_sel(input logic [IDX_W-1:0] idx);
        case (idx)
            IDX_W'(0): return SEL_ID;
            IDX_W'(1): return SEL_FREQ;
            IDX_W'(2): return SEL_LED;
            IDX_W'(3): return SEL_SW;
            IDX_W'(4): return SEL_RESET;
            default:   return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/board_ctrl_decode.sv
module board_ctrl_decode
    import board_ctrl_pkg::*;
(
    input  logic [OFS_W-1:0]  ofs,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    output bus_req_t          req
);
    // Byte lanes within a word are not decoded.
    logic unused_lsb;
    assign unused_lsb = ^ofs[1:0];

    always_comb begin
        req.wr    = wr;
        req.rd    = rd;
        req.sel   = idx_to_sel(ofs[OFS_W-1:2]);
        req.wdata = wdata;
    end
endmodule

// File: rtl/board_ctrl_sync.sv
module board_ctrl_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] held
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stg[s] <= '0;
                end else if (s == 0) begin
                    stg[s] <= async_in;
                end else begin
                    stg[s] <= stg[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    // Readable copy, loaded from the last synchronizer stage.
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else begin
            held <= stg[STAGES-1];
        end
    end
endmodule

// File: rtl/board_ctrl_trigger.sv
module board_ctrl_trigger
    import board_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic [DATA_W-1:0] wdata,
    output logic              req
);
    logic key_ok;
    assign key_ok = hit && (wdata == RESET_KEY);

    always_ff @(posedge clk) begin
        if (rst) begin
            req <= 1'b0;
        end else begin
            req <= key_ok && !req;
        end
    end

    a_r7_single_cycle: assert property (@(posedge clk) disable iff (rst)
        req |=> !req);
endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
    import board_ctrl_pkg::*;
#(
    parameter int          ADDR_W = 32,
    parameter int          LED_W  = 8,
    parameter int          SW_W   = 8,
    parameter logic [31:0] CLK_HZ = 32'd10_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [SW_W-1:0]   sw_in,
    output logic [LED_W-1:0]  led_out,
    output logic              reset_req
);
    bus_req_t          req;
    logic [LED_W-1:0]  led_q;
    logic [SW_W-1:0]   sw_q;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    generate
        if (ADDR_W > OFS_W) begin : g_upper
            logic unused_upper;
            assign unused_upper = ^bus_addr[ADDR_W-1:OFS_W];
        end
    endgenerate

    board_ctrl_decode u_decode (
        .ofs   (bus_addr[OFS_W-1:0]),
        .wr    (bus_wr),
        .rd    (bus_rd),
        .wdata (bus_wdata),
        .req   (req)
    );

    board_ctrl_sync #(.W(SW_W), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (sw_in),
        .held     (sw_q)
    );

    board_ctrl_trigger u_trigger (
        .clk   (clk),
        .rst   (rst),
        .hit   (req.wr && (req.sel == SEL_RESET)),
        .wdata (req.wdata),
        .req   (reset_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            led_q <= '0;
        end else if (req.wr && (req.sel == SEL_LED)) begin
            led_q <= req.wdata[LED_W-1:0];
        end
    end

    always_comb begin
        case (req.sel)
            SEL_ID:   rd_mux = BUILD_CODE;
            SEL_FREQ: rd_mux = CLK_HZ;
            SEL_LED:  rd_mux = DATA_W'(led_q);
            SEL_SW:   rd_mux = DATA_W'(sw_q);
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (req.rd) begin
            rdata_q <= rd_mux;
        end else begin
            rdata_q <= '0;
        end
    end

    assign bus_rdata = rdata_q;
    assign led_out   = led_q;

    a_r4_led_load: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr[OFS_W-1:2] == IDX_W'(2))
            |=> (led_out == $past(bus_wdata[LED_W-1:0])));

    a_r8_led_hold: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr[OFS_W-1:2] == IDX_W'(2)) |=> $stable(led_out));

    a_r6_req_cause: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> $past(bus_wr && bus_addr[OFS_W-1:2] == IDX_W'(4)
                            && bus_wdata == 32'h0000_DEAD));

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == '0));
endmodule

// File: tb/board_ctrl_regs_tb_top.sv
module board_ctrl_regs_tb_top;
    localparam int          LED_W  = 8;
    localparam int          SW_W   = 8;
    localparam logic [31:0] CLK_HZ = 32'd10_000_000;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic        bus_rd;
    logic [31:0] bus_rdata;
    logic [SW_W-1:0]  sw_in;
    logic [LED_W-1:0] led_out;
    logic        reset_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [LED_W-1:0] led_m;
    logic [SW_W-1:0]  sw_m;

    always #2.5 clk = ~clk;

    board_ctrl_regs #(.ADDR_W(32), .LED_W(LED_W), .SW_W(SW_W), .CLK_HZ(CLK_HZ)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .sw_in(sw_in), .led_out(led_out), .reset_req(reset_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_addr(input int idx, input logic [31:0] noise);
        return {noise[31:16], 14'(idx), noise[1:0]};
    endfunction

    function automatic logic [31:0] exp_read(input int idx);
        case (idx)
            0: return 32'h0927_2011;
            1: return CLK_HZ;
            2: return 32'(led_m);
            3: return 32'(sw_m);
            default: return 32'h0;
        endcase
    endfunction

    // Write, then one idle cycle; returns reset_req seen after the write edge.
    task automatic bus_write(input logic [31:0] a, input logic [31:0] d, output logic pulse);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        pulse = reset_req;
        bus_wr = 1'b0;
        @(negedge clk);
        chk("R7 idle after write", {31'b0, reset_req}, 32'h0);
    endtask

    task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic        p;
        void'($urandom(32'd1234));
        rst = 1'b1; bus_addr = '0; bus_wr = 0; bus_wdata = '0; bus_rd = 0;
        sw_in = 8'h00; led_m = '0; sw_m = '0;
        repeat (4) @(negedge clk);
        chk("R1 led in reset", 32'(led_out), 32'h0);
        chk("R1 req in reset", {31'b0, reset_req}, 32'h0);
        chk("R1 rdata in reset", bus_rdata, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 led after reset", 32'(led_out), 32'h0);
        bus_read(mk_addr(2, 0), rd); chk("R1 led read after reset", rd, 32'h0);

        bus_read(mk_addr(0, 0), rd); chk("R2 build code", rd, 32'h0927_2011);
        bus_read(mk_addr(1, 0), rd); chk("R3 clock rate", rd, CLK_HZ);

        bus_write(mk_addr(2, 0), 32'hFFFF_FFA5, p);
        led_m = 8'hA5;
        chk("R4 led out", 32'(led_out), 32'hA5);
        bus_read(mk_addr(2, 0), rd); chk("R4 led zero-extended read", rd, 32'h0000_00A5);

        // R5 latency: change on sw_in seen on the fourth edge, not the third
        sw_in = 8'h3C;
        @(negedge clk); @(negedge clk);
        bus_read(mk_addr(3, 0), rd); chk("R5 third edge old value", rd, 32'h0);
        bus_read(mk_addr(3, 0), rd); chk("R5 fourth edge new value", rd, 32'h3C);
        sw_m = 8'h3C;

        bus_write(mk_addr(4, 0), 32'h0000_DEAD, p); chk("R6 key fires", {31'b0, p}, 32'h1);
        bus_write(mk_addr(4, 0), 32'h0001_DEAD, p); chk("R6 upper bits block", {31'b0, p}, 32'h0);
        bus_write(mk_addr(4, 0), 32'h0000_DEAC, p); chk("R6 near key ignored", {31'b0, p}, 32'h0);
        bus_read(mk_addr(4, 0), rd); chk("R6 reset slot reads zero", rd, 32'h0);

        // R7 back-to-back key writes: one pulse then low
        bus_addr = mk_addr(4, 0); bus_wdata = 32'h0000_DEAD; bus_wr = 1'b1;
        @(negedge clk); chk("R7 first pulse", {31'b0, reset_req}, 32'h1);
        @(negedge clk); chk("R7 second write absorbed", {31'b0, reset_req}, 32'h0);
        bus_wr = 1'b0;
        @(negedge clk);

        // R8 writes to read-only and unmapped slots
        bus_write(mk_addr(0, 0), 32'h1234_5678, p);
        bus_write(mk_addr(1, 0), 32'h1, p);
        bus_write(mk_addr(3, 0), 32'hFF, p);
        bus_write(mk_addr(9, 0), 32'hFF, p);
        chk("R8 led untouched", 32'(led_out), 32'hA5);
        bus_read(mk_addr(0, 0), rd); chk("R8 build code intact", rd, 32'h0927_2011);
        bus_read(mk_addr(3, 0), rd); chk("R8 switch intact", rd, 32'h3C);
        bus_read(mk_addr(7, 0), rd); chk("R8 unmapped reads zero", rd, 32'h0);
        bus_read(mk_addr(16383, 0), rd); chk("R8 top of window zero", rd, 32'h0);

        // R9 aliasing
        bus_write(mk_addr(2, 32'hABCD_0003), 32'h5A, p);
        led_m = 8'h5A;
        chk("R9 aliased led write", 32'(led_out), 32'h5A);
        bus_read(mk_addr(1, 32'h7777_0002), rd); chk("R9 aliased read", rd, CLK_HZ);

        // R10 idle zero and read/write collision
        @(negedge clk); chk("R10 idle zero", bus_rdata, 32'h0);
        bus_addr = mk_addr(2, 0); bus_wdata = 32'hC3; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        chk("R10 same-cycle read returns old", bus_rdata, 32'h5A);
        chk("R4 same-cycle write lands", 32'(led_out), 32'hC3);
        bus_wr = 1'b0; bus_rd = 1'b0; led_m = 8'hC3;
        @(negedge clk);

        // Random phases
        for (int ph = 0; ph < 4; ph++) begin
            sw_in = 8'($urandom);
            repeat (5) @(negedge clk);
            sw_m = sw_in;
            for (int i = 0; i < 100; i++) begin
                int idx;
                logic [31:0] noise;
                logic [31:0] d;
                idx = ($urandom % 8 == 0) ? int'($urandom % 16384) : int'($urandom % 6);
                noise = $urandom;
                if ($urandom % 2 == 0) begin
                    d = ($urandom % 3 == 0) ? 32'h0000_DEAD : $urandom;
                    bus_write(mk_addr(idx, noise), d, p);
                    if (idx == 2) led_m = d[7:0];
                    chk("R6 random trigger", {31'b0, p}, {31'b0, (idx == 4 && d == 32'h0000_DEAD)});
                    chk("R4 random led", 32'(led_out), 32'(led_m));
                end else begin
                    bus_read(mk_addr(idx, noise), rd);
                    chk("R9 random read", rd, exp_read(idx));
                end
            end
        end

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 led cleared by reset", 32'(led_out), 32'h0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule